// File: doc/BRIEF.md
# Stack Processor Arithmetic Unit with Embedded Immediates

This block is the arithmetic stage of a 16-bit stack processor. Each accepted instruction word, together with the two operand cells, produces a double-cell result. The result is split into a high cell and a low cell. A flag tells the surrounding stack logic whether the high cell is pushed or dropped. The operand cells come from the parameter stack. The first operand is always the cell presented on `op_first`. The second operand is either `op_second` or a 5-bit immediate carried in the instruction. When it is the immediate, the operator chooses how that immediate is read: unsigned, sign-extended, or offset by minus sixteen.

The block registers its result one cycle after the request. A two-state output controller holds the state. `ST_IDLE` means no fresh result. `ST_LOADED` means the registered outputs carry the result of the previous cycle's request. The transitions are:
- IDLE→LOADED on `in_valid`.
- LOADED→LOADED on `in_valid`.
- LOADED→IDLE when `in_valid` is low.
- IDLE→IDLE when `in_valid` is low.

Instruction fields used (bit positions are fixed):
- bits 14..11: class, must be 0001.
- bit 10: truncate.
- bits 9..5: operator.
- bits 4..0: immediate field.

Bit 15 is ignored.

Top module: `stkalu_top`

## Requirements
- R1: An instruction whose bits 14..11 differ from 0001 sets `illegal_op` and gives zero in both result cells.
- R2: `keep_hi` equals the inverse of instruction bit 10. Bit 15 has no effect on any output.
- R3: An immediate field (bits 4..0) of zero selects `op_second` as the second operand. A nonzero field replaces it with an immediate.
- R4: The immediate is read as follows:
  - Unsigned (field zero-extended) for operators 0, 2, 4, 6, 8, 10, 12, 14, 17, 20, 21 and 22.
  - Offset (field minus 16) for operators 1, 3, 5, 7, 9 and 11.
  - Sign-extended (field minus 32 when the field is 16 or more) for operators 13, 15, 16, 18 and 24.
- R5: Operators 0 and 1 add. The low cell is the sum and the high cell is the carry out, 0 or 1.
- R6: Operator 2 gives first minus second. Operator 3 gives second minus first. The high cell is all ones on a borrow and zero otherwise.
- R7: Comparisons place all ones (true) or zero (false) in the low cell and zero in the high cell. The operators are:
  - 4: first < second, unsigned.
  - 5: second < first, signed.
  - 6: first > second, unsigned.
  - 7: second > first, signed.
  - 8 and 9: equal.
  - 10 and 11: not equal.
- R8: Operators 12 and 13 form the full unsigned product across both cells. Operators 14 and 15 form the full signed product.
- R9: Operator 16 gives AND, 17 gives OR and 18 gives XOR of the two operands. The high cell is zero.
- R10: The shift amount is the second operand. Operator 20 is a logical right shift, 21 a left shift and 22 an arithmetic right shift of the first operand. An amount of 16 or more gives zero for 20 and 21, and a full sign fill for 22. The high cell is zero.
- R11: Operator 24 with an immediate gives the immediate's bits 3..0 above the first operand's bits 11..0. Without an immediate it gives the first operand's bits 3..0 above the second operand's bits 11..0.
- R12: Operators 19, 23 and 25 to 31 set `illegal_op` and give zero in both cells.
- R13: Reset clears all outputs. Results appear with `out_valid` one cycle after `in_valid`. The result outputs keep their value while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request: evaluate this instruction |
| instr | input | 16 | Instruction word |
| op_first | input | DATA_W | First operand cell |
| op_second | input | DATA_W | Second operand cell (used when the immediate field is zero) |
| out_valid | output | 1 | Registered result is fresh this cycle |
| res_hi | output | DATA_W | High cell of the double result |
| res_lo | output | DATA_W | Low cell of the double result |
| keep_hi | output | 1 | High 1: keep both cells; low: truncate to the low cell |
| illegal_op | output | 1 | Class mismatch or reserved operator |

## Verification
The bench targets each of the following mistakes:
- Operand reversal on odd operators. A design that ignores it returns first minus second for operator 3, and flips every signed comparison.
- The offset immediate. Reading it as unsigned turns field 3 into +3 instead of −13, and the sum and carry are both wrong.
- Shift amounts of 16 or more. A design that only uses the low four bits of the amount shifts by the wrong count instead of returning zero or a sign fill.
- Sign handling on the products. A design that mixes up signedness returns 0xFFFE0001 where 1 is due.

Further checks cover the reserved codes, foreign classes and the hold of outputs after a request.

// File: rtl/stkalu_pkg.sv
package stkalu_pkg;

    typedef enum logic [1:0] {
        IMM_UNS,
        IMM_SGN,
        IMM_OFS
    } imm_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_LOADED
    } out_state_e;

    localparam logic [3:0] ALU_CLASS = 4'b0001;
    localparam int         LOW_KEEP  = 12;

    // How the 5-bit field is read, chosen by the operator
    function automatic imm_kind_e imm_kind_of(input logic [4:0] op);
        imm_kind_e k;
        if (op < 5'd12) begin
            k = op[0] ? IMM_OFS : IMM_UNS;
        end else begin
            unique case (op)
                5'd13, 5'd15, 5'd16, 5'd18, 5'd24: k = IMM_SGN;
                default:                           k = IMM_UNS;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/stkalu_operand_sel.sv
module stkalu_operand_sel
    import stkalu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [4:0]        op,
    input  logic [4:0]        field,
    input  logic [DATA_W-1:0] second,
    output logic [DATA_W-1:0] operand_b,
    output logic              use_imm
);

    localparam int EXT_W = DATA_W - 5;

    logic [DATA_W-1:0] imm_u;
    logic [DATA_W-1:0] imm_s;
    logic [DATA_W-1:0] imm_o;

    always_comb begin
        imm_u   = {{EXT_W{1'b0}}, field};
        imm_s   = {{EXT_W{field[4]}}, field};
        imm_o   = {{EXT_W{~field[4]}}, ~field[4], field[3:0]};
        use_imm = (field != 5'd0);
        if (!use_imm) begin
            operand_b = second;
        end else begin
            unique case (imm_kind_of(op))
                IMM_SGN: operand_b = imm_s;
                IMM_OFS: operand_b = imm_o;
                default: operand_b = imm_u;
            endcase
        end
    end

endmodule

// File: rtl/stkalu_core.sv
module stkalu_core
    import stkalu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [4:0]        op,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] hi,
    output logic [DATA_W-1:0] lo,
    output logic              reserved
);

    localparam int SHW = $clog2(DATA_W);
    localparam int DW2 = 2 * DATA_W;
    localparam int UPW = DATA_W - LOW_KEEP;

    logic              rev;
    logic [DATA_W-1:0] p, q;
    logic [DATA_W:0]   sum_w, diff_w;
    logic              flag;
    logic [DW2-1:0]    uprod, sprod;
    logic [SHW-1:0]    sh;
    logic              big;
    logic [DATA_W-1:0] asr_v;

    always_comb begin
        rev    = (op < 5'd12) && op[0];
        p      = rev ? b : a;
        q      = rev ? a : b;
        sum_w  = {1'b0, p} + {1'b0, q};
        diff_w = {1'b0, p} - {1'b0, q};
        uprod  = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
        sprod  = {{DATA_W{a[DATA_W-1]}}, a} * {{DATA_W{b[DATA_W-1]}}, b};
        sh     = b[SHW-1:0];
        big    = |b[DATA_W-1:SHW];
        asr_v  = $signed(a) >>> sh;
        flag   = 1'b0;
        hi       = '0;
        lo       = '0;
        reserved = 1'b0;
        unique case (op)
            5'd0, 5'd1: begin
                hi = {{(DATA_W-1){1'b0}}, sum_w[DATA_W]};
                lo = sum_w[DATA_W-1:0];
            end
            5'd2, 5'd3: begin
                hi = {DATA_W{diff_w[DATA_W]}};
                lo = diff_w[DATA_W-1:0];
            end
            5'd4, 5'd5: begin
                flag = op[0] ? ($signed(p) < $signed(q)) : (p < q);
                lo   = {DATA_W{flag}};
            end
            5'd6, 5'd7: begin
                flag = op[0] ? ($signed(p) > $signed(q)) : (p > q);
                lo   = {DATA_W{flag}};
            end
            5'd8, 5'd9:   lo = {DATA_W{p == q}};
            5'd10, 5'd11: lo = {DATA_W{p != q}};
            5'd12, 5'd13: {hi, lo} = uprod;
            5'd14, 5'd15: {hi, lo} = sprod;
            5'd16: lo = a & b;
            5'd17: lo = a | b;
            5'd18: lo = a ^ b;
            5'd20: lo = big ? '0 : (a >> sh);
            5'd21: lo = big ? '0 : (a << sh);
            5'd22: lo = big ? {DATA_W{a[DATA_W-1]}} : asr_v;
            5'd24: lo = use_imm ? {b[UPW-1:0], a[LOW_KEEP-1:0]}
                                : {a[UPW-1:0], b[LOW_KEEP-1:0]};
            default: reserved = 1'b1;
        endcase
    end

endmodule

// File: rtl/stkalu_top.sv
module stkalu_top
    import stkalu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       instr,
    input  logic [DATA_W-1:0] op_first,
    input  logic [DATA_W-1:0] op_second,
    output logic              out_valid,
    output logic [DATA_W-1:0] res_hi,
    output logic [DATA_W-1:0] res_lo,
    output logic              keep_hi,
    output logic              illegal_op
);

    out_state_e        st_q, st_d;
    logic [4:0]        op;
    logic [DATA_W-1:0] operand_b;
    logic              use_imm;
    logic [DATA_W-1:0] core_hi, core_lo;
    logic              core_rsv;
    logic              class_ok;
    logic              bad;
    logic              unused_bits;

    assign op          = instr[9:5];
    assign class_ok    = (instr[14:11] == ALU_CLASS);
    assign bad         = !class_ok || core_rsv;
    assign unused_bits = instr[15];

    stkalu_operand_sel #(.DATA_W(DATA_W)) u_sel (
        .op        (op),
        .field     (instr[4:0]),
        .second    (op_second),
        .operand_b (operand_b),
        .use_imm   (use_imm)
    );

    stkalu_core #(.DATA_W(DATA_W)) u_core (
        .op       (op),
        .use_imm  (use_imm),
        .a        (op_first),
        .b        (operand_b),
        .hi       (core_hi),
        .lo       (core_lo),
        .reserved (core_rsv)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE:   st_d = in_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: st_d = in_valid ? ST_LOADED : ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi     <= '0;
            res_lo     <= '0;
            keep_hi    <= 1'b0;
            illegal_op <= 1'b0;
        end else if (in_valid) begin
            res_hi     <= bad ? '0 : core_hi;
            res_lo     <= bad ? '0 : core_lo;
            keep_hi    <= !instr[10];
            illegal_op <= bad;
        end
    end

    assign out_valid = (st_q == ST_LOADED);

    AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R13
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_lo) && $stable(res_hi))); // R13
    AST_KEEP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (keep_hi == !$past(instr[10]))); // R2
    AST_FOREIGN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[14:11] != 4'b0001) |=> illegal_op); // R1
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (res_hi == '0 && res_lo == '0)); // R12
    AST_CMP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && class_ok && op >= 5'd4 && op <= 5'd11)
        |=> (res_hi == '0 && (res_lo == '0 || res_lo == '1))); // R7

endmodule

// File: tb/stkalu_top_tb_top.sv
`timescale 1ns/1ps
module stkalu_top_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [15:0]  instr = '0;
    logic [W-1:0] op_first = '0;
    logic [W-1:0] op_second = '0;
    logic         out_valid;
    logic [W-1:0] res_hi, res_lo;
    logic         keep_hi, illegal_op;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    stkalu_top #(.DATA_W(W)) dut_i (
        .clk, .rst_n, .in_valid, .instr, .op_first, .op_second,
        .out_valid, .res_hi, .res_lo, .keep_hi, .illegal_op
    );

    function automatic logic [15:0] mk(input logic e, input logic t,
                                       input logic [4:0] op, input logic [4:0] f);
        return {e, 4'b0001, t, op, f};
    endfunction

    // drive one request, then check the registered result one cycle later
    task automatic run(input string req, input logic [15:0] ins,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] ehi, input logic [W-1:0] elo,
                       input logic eill);
        @(negedge clk);
        instr = ins; op_first = a; op_second = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b1 || res_hi !== ehi || res_lo !== elo ||
            illegal_op !== eill || keep_hi !== !ins[10]) begin
            errors++;
            $display("FAIL %s instr=%h: got v=%b hi=%h lo=%h ill=%b keep=%b, exp v=1 hi=%h lo=%h ill=%b keep=%b",
                     req, ins, out_valid, res_hi, res_lo, illegal_op, keep_hi,
                     ehi, elo, eill, !ins[10]);
        end
    endtask

    task automatic t_reset;
        checks++;
        if (out_valid !== 0 || res_hi !== 0 || res_lo !== 0 || illegal_op !== 0 || keep_hi !== 0) begin
            errors++;
            $display("FAIL R13 reset: v=%b hi=%h lo=%h ill=%b keep=%b, exp all zero",
                     out_valid, res_hi, res_lo, illegal_op, keep_hi);
        end
    endtask

    task automatic t_sums;
        run("R5 R3 add stack carry", mk(0,0,5'd0,5'd0), 16'hFFFF, 16'h0002, 16'h0001, 16'h0001, 0);
        run("R4 add uimm", mk(0,0,5'd0,5'd5), 16'h0010, 16'h1234, 16'h0000, 16'h0015, 0);
        run("R4 R5 add oimm", mk(0,0,5'd1,5'd3), 16'h0020, 16'h9999, 16'h0001, 16'h0013, 0);
    endtask

    task automatic t_diffs;
        run("R6 sub uimm borrow", mk(0,0,5'd2,5'd7), 16'h0005, 16'h0000, 16'hFFFF, 16'hFFFE, 0);
        run("R6 reversed sub oimm", mk(0,0,5'd3,5'd31), 16'h0004, 16'h0000, 16'h0000, 16'h000B, 0);
        run("R6 reversed sub stack", mk(0,0,5'd3,5'd0), 16'h000A, 16'h0003, 16'hFFFF, 16'hFFF9, 0);
    endtask

    task automatic t_compares;
        run("R7 ult false", mk(0,0,5'd4,5'd0), 16'h8000, 16'h0001, 16'h0000, 16'h0000, 0);
        run("R7 ugt true", mk(0,0,5'd6,5'd0), 16'h8000, 16'h0001, 16'h0000, 16'hFFFF, 0);
        run("R7 signed second<first stack", mk(0,0,5'd5,5'd0), 16'h0001, 16'h8000, 16'h0000, 16'hFFFF, 0);
        run("R7 R4 signed oimm<first false", mk(0,0,5'd5,5'd1), 16'hFFF0, 16'h0000, 16'h0000, 16'h0000, 0);
        run("R7 signed second>first", mk(0,0,5'd7,5'd0), 16'hFFFF, 16'h0001, 16'h0000, 16'hFFFF, 0);
        run("R7 eq uimm", mk(0,0,5'd8,5'd9), 16'h0009, 16'h0000, 16'h0000, 16'hFFFF, 0);
        run("R7 eq oimm zero", mk(0,0,5'd9,5'd16), 16'h0000, 16'h5555, 16'h0000, 16'hFFFF, 0);
        run("R7 neq stack equal", mk(0,0,5'd10,5'd0), 16'h0003, 16'h0003, 16'h0000, 16'h0000, 0);
        run("R7 neq oimm", mk(0,0,5'd11,5'd17), 16'h0002, 16'h0000, 16'h0000, 16'hFFFF, 0);
    endtask

    task automatic t_products;
        run("R8 unsigned stack", mk(0,0,5'd12,5'd0), 16'hFFFF, 16'hFFFF, 16'hFFFE, 16'h0001, 0);
        run("R8 signed stack", mk(0,0,5'd15,5'd0), 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0001, 0);
        run("R8 R4 unsigned simm", mk(0,0,5'd13,5'd31), 16'h0002, 16'h0000, 16'h0001, 16'hFFFE, 0);
        run("R8 signed uimm", mk(0,0,5'd14,5'd3), 16'hFFFE, 16'h0000, 16'hFFFF, 16'hFFFA, 0);
    endtask

    task automatic t_logic;
        run("R9 and simm", mk(0,0,5'd16,5'd16), 16'h1234, 16'h0000, 16'h0000, 16'h1230, 0);
        run("R9 or uimm", mk(0,0,5'd17,5'd8), 16'h1230, 16'h0000, 16'h0000, 16'h1238, 0);
        run("R9 xor simm", mk(0,0,5'd18,5'd31), 16'h00FF, 16'h0000, 16'h0000, 16'hFF00, 0);
        run("R9 and stack", mk(0,0,5'd16,5'd0), 16'hF0F0, 16'h3C3C, 16'h0000, 16'h3030, 0);
    endtask

    task automatic t_shifts;
        run("R10 lsr imm", mk(0,0,5'd20,5'd4), 16'h8010, 16'h0000, 16'h0000, 16'h0801, 0);
        run("R10 lsl imm", mk(0,0,5'd21,5'd3), 16'h1001, 16'h0000, 16'h0000, 16'h8008, 0);
        run("R10 asr imm", mk(0,0,5'd22,5'd4), 16'h8010, 16'h0000, 16'h0000, 16'hF801, 0);
        run("R10 lsr by 16", mk(0,0,5'd20,5'd0), 16'hFFFF, 16'h0010, 16'h0000, 16'h0000, 0);
        run("R10 asr by 32 neg", mk(0,0,5'd22,5'd0), 16'h8000, 16'h0020, 16'h0000, 16'hFFFF, 0);
        run("R10 asr by 20 pos", mk(0,0,5'd22,5'd0), 16'h7FFF, 16'h0014, 16'h0000, 16'h0000, 0);
        run("R10 lsl by 15", mk(0,0,5'd21,5'd0), 16'h0001, 16'h000F, 16'h0000, 16'h8000, 0);
    endtask

    task automatic t_set_upper;
        run("R11 simm upper", mk(0,0,5'd24,5'd21), 16'hABCD, 16'h0000, 16'h0000, 16'h5BCD, 0);
        run("R11 stack upper", mk(0,0,5'd24,5'd0), 16'h0003, 16'h9876, 16'h0000, 16'h3876, 0);
    endtask

    task automatic t_illegal;
        run("R12 op 19", mk(0,0,5'd19,5'd0), 16'h1111, 16'h2222, 16'h0000, 16'h0000, 1);
        run("R12 op 28", mk(0,0,5'd28,5'd3), 16'h1111, 16'h2222, 16'h0000, 16'h0000, 1);
        run("R12 op 31", mk(0,0,5'd31,5'd0), 16'h1111, 16'h2222, 16'h0000, 16'h0000, 1);
        run("R1 foreign class", 16'h0418, 16'h1111, 16'h2222, 16'h0000, 16'h0000, 1);
    endtask

    task automatic t_keep;
        run("R2 truncate bit10 and bit15", mk(1,1,5'd0,5'd1), 16'hFFFF, 16'h0000, 16'h0001, 16'h0000, 0);
        run("R2 keep both", mk(1,0,5'd0,5'd1), 16'hFFFF, 16'h0000, 16'h0001, 16'h0000, 0);
    endtask

    task automatic t_hold;
        run("R13 load", mk(0,0,5'd0,5'd0), 16'h0100, 16'h0023, 16'h0000, 16'h0123, 0);
        instr = mk(0,0,5'd2,5'd0); op_first = 16'h7777; op_second = 16'h1;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 0 || res_lo !== 16'h0123 || res_hi !== 16'h0000) begin
            errors++;
            $display("FAIL R13 hold: got v=%b hi=%h lo=%h, exp v=0 hi=0000 lo=0123",
                     out_valid, res_hi, res_lo);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_sums();
        t_diffs();
        t_compares();
        t_products();
        t_logic();
        t_shifts();
        t_set_upper();
        t_illegal();
        t_keep();
        t_hold();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got running, exp finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule